// File: doc/BRIEF.md
# LCD panel line timing generator

This block produces the five row and column control strobes that a row/column-addressed LCD panel needs: a vertical start pulse, a vertical clock, a horizontal start pulse, and an even and an odd row enable. It runs from a pixel-clock enable at a fixed number of pixel periods per video line. It counts pixel periods within the line and lines within the field, and it decodes the strobes from those two counts. Line-sync and field-sync pulses realign the counters to incoming video. When the sync pulses are absent, the counters free-run at the nominal line and field length.

A mode select chooses between 525-line and 625-line operation. In 625-line mode the block leaves out one line in every six from a fixed starting line, so the panel still receives its nominal number of rows. The starting line depends on the field-parity input. The row enables alternate even/odd over the lines that are kept, and the vertical clock marks each even row. Every output is a registered, active-low strobe that changes only on a pixel-clock boundary.

Top module: `lcdPanelTiming`

## Requirements
- R1: While `rstN` is low, and after it is released until the first active decode, all five outputs are high.
- R2: Each line lasts `PIX_PER_LINE` pixel periods (pixel positions 0 upward). Lines are numbered from 1 within a field. Without sync pulses the line number wraps back to 1 after line `LINES_525` (mode625=0) or `LINES_625` (mode625=1).
- R3: `vplN` is low during the first `VPL_LEN` pixel positions of line `FIRST_LINE` (22), once per field.
- R4: `hplN` is low for exactly one pixel period, at pixel position `HPL_POS`, on every active row.
- R5: `vckN` is low for `VCK_LEN` (3) pixel periods starting `VCK_LEAD` (3) positions before `HPL_POS`, only on even rows. Row 0 is the first active line, line 22.
- R6: The row-enable window starts `REN_GAP` (5) positions after the horizontal start pulse ends and lasts `REN_LEN` pixel periods. `reneN` is low in that window on even rows and `renoN` on odd rows. The two are never low together.
- R7: Active rows start at line 22. Each field has exactly `ROWS` (240) active rows, and no strobe other than `vplN` goes low outside them. In 525-line mode the active rows are lines 22 to 261.
- R8: In 625-line mode, lines `28+6k` of an odd field (fieldOdd=1) and lines `25+6k` of an even field (fieldOdd=0) are skipped: no vertical clock, horizontal start or row enable. The row parity continues over the kept lines. In 525-line mode no line is skipped.
- R9: A `lineSync` pulse moves the count to pixel 0 of the next line number. A `fieldSync` pulse moves it to pixel 0 of line 1. Both act only when `pixEn` is high, and `fieldSync` takes priority.
- R10: An output register loads on an edge only when `pixEn` is high. On an edge with `pixEn` low, all outputs and counts hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Pixel-clock enable, one per pixel period |
| lineSync | input | 1 | Line realignment pulse |
| fieldSync | input | 1 | Field realignment pulse |
| fieldOdd | input | 1 | 1 = odd field, 0 = even field |
| mode625 | input | 1 | 0 = 525-line, 1 = 625-line operation |
| vplN | output | 1 | Vertical start pulse, active low |
| vckN | output | 1 | Vertical clock, active low |
| hplN | output | 1 | Horizontal start pulse, active low |
| reneN | output | 1 | Even row enable, active low |
| renoN | output | 1 | Odd row enable, active low |

## Verification
The in-RTL properties check the invariants that hold on every cycle:
- the pixel and line counts stay in range;
- the two row enables are never low together;
- the horizontal start lasts one pixel period;
- everything holds while the pixel enable is low;
- no active row sits on a skipped line.

The exact pixel positions of each strobe, the count of 240 rows per field and the skip pattern itself can only be shown by the bench's scenarios. The bench runs full fields in both modes and both parities, plus free-run wrap, mid-line resync and a throttled pixel enable. It compares every output on every cycle against positions computed from the requirements.

// File: rtl/lcdTimingPkg.sv
package lcdTimingPkg;

  // First skipped field line and spacing of skipped lines in 625-line mode
  localparam int unsigned ODD_SKIP_FIRST  = 28;
  localparam int unsigned EVEN_SKIP_FIRST = 25;
  localparam int unsigned SKIP_PERIOD     = 6;

  // Strobes from the control to the counter datapath
  typedef struct packed {
    logic step;
    logic lineRestart;
    logic fieldRestart;
  } dpCtl_t;

  function automatic logic skipLine(input int unsigned ln, input logic m625,
                                    input logic oddF);
    int unsigned first;
    first = oddF ? ODD_SKIP_FIRST : EVEN_SKIP_FIRST;
    if (!m625) return 1'b0;
    if (ln < first) return 1'b0;
    return ((ln - first) % SKIP_PERIOD) == 0;
  endfunction

endpackage

// File: rtl/lcdLineCounter.sv
module lcdLineCounter
  import lcdTimingPkg::*;
#(
  parameter int PIX_PER_LINE = 384,
  parameter int LINES_525    = 262,
  parameter int LINES_625    = 312,
  parameter int PW           = $clog2(PIX_PER_LINE),
  parameter int LW           = $clog2(LINES_625 + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic          mode625,
  output logic [PW-1:0] pixCnt,
  output logic [LW-1:0] lineCnt,
  output logic [LW-1:0] nextLine,
  output logic          lineAdv
);

  logic lastPix;
  logic lastLine;

  always_comb begin
    lastPix  = (pixCnt == PW'(PIX_PER_LINE - 1));
    lastLine = mode625 ? (lineCnt >= LW'(LINES_625)) : (lineCnt >= LW'(LINES_525));
    lineAdv  = ctl.step && (ctl.fieldRestart || ctl.lineRestart || lastPix);
    if (ctl.fieldRestart || lastLine) nextLine = LW'(1);
    else                              nextLine = lineCnt + LW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineCnt <= LW'(1);
    end else if (ctl.step) begin
      if (ctl.fieldRestart || ctl.lineRestart || lastPix) pixCnt <= '0;
      else                                               pixCnt <= pixCnt + PW'(1);
      if (lineAdv) lineCnt <= nextLine;
    end
  end

  // R2
  pix_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixCnt <= PW'(PIX_PER_LINE - 1));

  // R2
  line_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineCnt >= LW'(1)) && (lineCnt <= LW'(LINES_625)));

endmodule

// File: rtl/lcdStrobeCtl.sv
module lcdStrobeCtl
  import lcdTimingPkg::*;
#(
  parameter int FIRST_LINE = 22,
  parameter int ROWS       = 240,
  parameter int HPL_POS    = 8,
  parameter int VCK_LEAD   = 3,
  parameter int VCK_LEN    = 3,
  parameter int REN_GAP    = 5,
  parameter int REN_LEN    = 332,
  parameter int VPL_LEN    = 4,
  parameter int PW         = 9,
  parameter int LW         = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixEn,
  input  logic          lineSync,
  input  logic          fieldSync,
  input  logic          fieldOdd,
  input  logic          mode625,
  input  logic [PW-1:0] pixCnt,
  input  logic [LW-1:0] lineCnt,
  input  logic [LW-1:0] nextLine,
  input  logic          lineAdv,
  output dpCtl_t        ctl,
  output logic          vplN,
  output logic          vckN,
  output logic          hplN,
  output logic          reneN,
  output logic          renoN
);

  localparam int unsigned VCK_START = HPL_POS - VCK_LEAD;
  localparam int unsigned VCK_END   = VCK_START + VCK_LEN;
  localparam int unsigned REN_START = HPL_POS + 1 + REN_GAP;
  localparam int unsigned REN_END   = REN_START + REN_LEN;
  localparam int          KW        = $clog2(ROWS + 1);

  logic [KW-1:0] keptCnt;
  logic          rowActive;
  logic          rowOdd;
  int unsigned   pixU;
  int unsigned   lineU;
  int unsigned   newLineU;
  logic          vplLow, vckLow, hplLow, renWin;

  assign ctl = '{step: pixEn, lineRestart: lineSync, fieldRestart: fieldSync};

  always_comb begin
    pixU     = 32'(pixCnt);
    lineU    = 32'(lineCnt);
    newLineU = 32'(nextLine);
    vplLow   = (lineU == FIRST_LINE) && (pixU < VPL_LEN);
    vckLow   = rowActive && !rowOdd && (pixU >= VCK_START) && (pixU < VCK_END);
    hplLow   = rowActive && (pixU == HPL_POS);
    renWin   = rowActive && (pixU >= REN_START) && (pixU < REN_END);
  end

  // Row tracking, updated as the count enters a new line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keptCnt   <= '0;
      rowActive <= 1'b0;
      rowOdd    <= 1'b0;
    end else if (lineAdv) begin
      if (newLineU < FIRST_LINE) begin
        keptCnt   <= '0;
        rowActive <= 1'b0;
      end else if (skipLine(newLineU, mode625, fieldOdd)) begin
        rowActive <= 1'b0;
      end else if (keptCnt < KW'(ROWS)) begin
        rowActive <= 1'b1;
        rowOdd    <= keptCnt[0];
        keptCnt   <= keptCnt + KW'(1);
      end else begin
        rowActive <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vplN  <= 1'b1;
      vckN  <= 1'b1;
      hplN  <= 1'b1;
      reneN <= 1'b1;
      renoN <= 1'b1;
    end else if (pixEn) begin
      vplN  <= !vplLow;
      vckN  <= !vckLow;
      hplN  <= !hplLow;
      reneN <= !(renWin && !rowOdd);
      renoN <= !(renWin && rowOdd);
    end
  end

  // R6
  ren_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!reneN && !renoN));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> $stable({vplN, vckN, hplN, reneN, renoN}));

  // R4
  hpl_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && !hplN) |=> hplN);

  // R8
  no_skip_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowActive && $stable(mode625) && $stable(fieldOdd))
      |-> !skipLine(32'(lineCnt), mode625, fieldOdd));

endmodule

// File: rtl/lcdPanelTiming.sv
module lcdPanelTiming
  import lcdTimingPkg::*;
#(
  parameter int PIX_PER_LINE = 384,
  parameter int LINES_525    = 262,
  parameter int LINES_625    = 312,
  parameter int FIRST_LINE   = 22,
  parameter int ROWS         = 240,
  parameter int HPL_POS      = 8,
  parameter int VCK_LEAD     = 3,
  parameter int VCK_LEN      = 3,
  parameter int REN_GAP      = 5,
  parameter int REN_LEN      = 332,
  parameter int VPL_LEN      = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic pixEn,
  input  logic lineSync,
  input  logic fieldSync,
  input  logic fieldOdd,
  input  logic mode625,
  output logic vplN,
  output logic vckN,
  output logic hplN,
  output logic reneN,
  output logic renoN
);

  localparam int PW = $clog2(PIX_PER_LINE);
  localparam int LW = $clog2(LINES_625 + 1);

  dpCtl_t        ctl;
  logic [PW-1:0] pixCnt;
  logic [LW-1:0] lineCnt;
  logic [LW-1:0] nextLine;
  logic          lineAdv;

  lcdLineCounter #(
    .PIX_PER_LINE(PIX_PER_LINE), .LINES_525(LINES_525), .LINES_625(LINES_625),
    .PW(PW), .LW(LW)
  ) uCnt (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mode625(mode625),
    .pixCnt(pixCnt), .lineCnt(lineCnt), .nextLine(nextLine), .lineAdv(lineAdv)
  );

  lcdStrobeCtl #(
    .FIRST_LINE(FIRST_LINE), .ROWS(ROWS), .HPL_POS(HPL_POS),
    .VCK_LEAD(VCK_LEAD), .VCK_LEN(VCK_LEN), .REN_GAP(REN_GAP),
    .REN_LEN(REN_LEN), .VPL_LEN(VPL_LEN), .PW(PW), .LW(LW)
  ) uCtl (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .lineSync(lineSync),
    .fieldSync(fieldSync), .fieldOdd(fieldOdd), .mode625(mode625),
    .pixCnt(pixCnt), .lineCnt(lineCnt), .nextLine(nextLine), .lineAdv(lineAdv),
    .ctl(ctl), .vplN(vplN), .vckN(vckN), .hplN(hplN), .reneN(reneN), .renoN(renoN)
  );

endmodule

// File: tb/tb_lcdPanelTiming.sv
module tb_lcdPanelTiming;

  localparam int PIX   = 40;
  localparam int L525  = 262;
  localparam int L625  = 312;
  localparam int FIRST = 22;
  localparam int ROWS  = 240;
  localparam int HPOS  = 8;
  localparam int VLEAD = 3;
  localparam int VLEN  = 3;
  localparam int RGAP  = 5;
  localparam int RLEN  = 20;
  localparam int VPLL  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixEn = 1'b0, lineSync = 1'b0, fieldSync = 1'b0;
  logic fieldOdd = 1'b0, mode625 = 1'b0;
  logic vplN, vckN, hplN, reneN, renoN;

  int checks = 0, fails = 0, cycles = 0, hplFalls = 0;
  int mPix = 0, mLine = 1;
  logic eVpl = 1'b1, eVck = 1'b1, eHpl = 1'b1, eRene = 1'b1, eReno = 1'b1;
  logic prevHpl = 1'b1;
  logic done = 1'b0;
  string tag = "R2";

  always #4 clk = ~clk;

  lcdPanelTiming #(
    .PIX_PER_LINE(PIX), .LINES_525(L525), .LINES_625(L625), .FIRST_LINE(FIRST),
    .ROWS(ROWS), .HPL_POS(HPOS), .VCK_LEAD(VLEAD), .VCK_LEN(VLEN),
    .REN_GAP(RGAP), .REN_LEN(RLEN), .VPL_LEN(VPLL)
  ) dut (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .lineSync(lineSync),
    .fieldSync(fieldSync), .fieldOdd(fieldOdd), .mode625(mode625),
    .vplN(vplN), .vckN(vckN), .hplN(hplN), .reneN(reneN), .renoN(renoN)
  );

  function automatic bit tbSkip(int ln, logic m, logic odd);
    int f = odd ? 28 : 25;
    return m && (ln >= f) && ((ln - f) % 6 == 0);
  endfunction

  // Row index of a line by counting kept lines from 22; -1 when inactive
  function automatic int rowOf(int ln, logic m, logic odd);
    int k = 0;
    if (ln < FIRST || tbSkip(ln, m, odd)) return -1;
    for (int l = FIRST; l < ln; l++) if (!tbSkip(l, m, odd)) k++;
    return (k < ROWS) ? k : -1;
  endfunction

  task automatic chk(string rq, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s/%s %s line=%0d pix=%0d actual=%b expected=%b",
               rq, tag, nm, mLine, mPix, act, exp);
    end
  endtask

  // Drive one cycle from a negedge; compare at the following negedge
  task automatic step(logic pe, logic ls, logic fs);
    int row, rs, vs;
    pixEn = pe; lineSync = ls; fieldSync = fs;
    if (pe) begin
      row = rowOf(mLine, mode625, fieldOdd);
      rs  = HPOS + 1 + RGAP;
      vs  = HPOS - VLEAD;
      eVpl  = !(mLine == FIRST && mPix < VPLL);
      eHpl  = !(row >= 0 && mPix == HPOS);
      eVck  = !(row >= 0 && row % 2 == 0 && mPix >= vs && mPix < vs + VLEN);
      eRene = !(row >= 0 && row % 2 == 0 && mPix >= rs && mPix < rs + RLEN);
      eReno = !(row >= 0 && row % 2 == 1 && mPix >= rs && mPix < rs + RLEN);
      if (fs) begin mPix = 0; mLine = 1; end
      else if (ls || mPix == PIX - 1) begin
        mPix = 0;
        mLine = (mLine >= (mode625 ? L625 : L525)) ? 1 : mLine + 1;
      end else mPix++;
    end
    @(posedge clk);
    @(negedge clk);
    cycles++;
    chk("R3", "vplN", vplN, eVpl);
    chk("R4", "hplN", hplN, eHpl);
    chk("R5", "vckN", vckN, eVck);
    chk("R6", "reneN", reneN, eRene);
    chk("R6", "renoN", renoN, eReno);
    if (prevHpl && !hplN) hplFalls++;
    prevHpl = hplN;
  endtask

  task automatic startField(logic m, logic odd, string t);
    tag = t;
    mode625 = m; fieldOdd = odd;
    hplFalls = 0;
    step(1'b1, 1'b0, 1'b1);
  endtask

  task automatic runLines(int n, logic throttle);
    for (int i = 0; i < n * PIX; i++) begin
      step(1'b1, 1'b0, 1'b0);
      if (throttle) step(1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic chkRows(string t);
    checks++;
    if (hplFalls != ROWS) begin
      fails++;
      $display("FAIL R7/%s row count actual=%0d expected=%0d", t, hplFalls, ROWS);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    @(negedge clk);
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if ({vplN, vckN, hplN, reneN, renoN} !== 5'b11111) begin
      fails++;
      $display("FAIL R1 outputs actual=%b expected=11111", {vplN, vckN, hplN, reneN, renoN});
    end
    rstN = 1'b1;
    tag = "R1";
    step(1'b1, 1'b0, 1'b0);   // first decode at line 1 pixel 0: all high

    // R2 R7: 525-line field, then free-run wrap into the next field
    startField(1'b0, 1'b1, "R2");
    runLines(L525, 1'b0);
    chkRows("R2");
    runLines(25, 1'b0);

    // R8: 625-line odd and even fields
    startField(1'b1, 1'b1, "R8");
    runLines(L625, 1'b0);
    chkRows("R8");
    startField(1'b1, 1'b0, "R8");
    runLines(L625, 1'b0);
    chkRows("R8");

    // R10: throttled pixel enable
    startField(1'b0, 1'b0, "R10");
    runLines(30, 1'b1);

    // R9: mid-line resync, and a sync pulse without pixel enable
    startField(1'b0, 1'b1, "R9");
    runLines(20, 1'b0);
    for (int l = 0; l < 10; l++) begin
      for (int p = 0; p < 17; p++) step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b0);
    end
    runLines(3, 1'b0);
    for (int p = 0; p < 11; p++) step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    runLines(2, 1'b0);

    finishRun();
  end

endmodule